// File: doc/BRIEF.md
# Keyed Index/Data Configuration Port

This block is the configuration front end of a legacy-style I/O controller. A host reaches it through two adjacent byte-wide I/O addresses: an index address that selects a register and a data address that reads or writes the selected register. After reset the port is locked. While it is locked, writes to the index address go to a key matcher. Configuration access opens only after a fixed four-byte key has been written there in order.

Once the port is open, the host writes a register number to the index address and then accesses the data address. A small set of global registers lives inside the block: a bank-select register that picks the logical device, a 16-bit chip identifier, and a revision nibble. Register numbers at and above the device window base go out on a simple register bus to the logical device currently selected. The host closes the port by writing the exit code to the exit register, which returns the block to the locked state. The host side is a synchronous strobe interface. A write or read takes effect in the cycle its strobe is sampled, and read data is returned combinationally while the read strobe is high.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked, the selected logical device is 0x00, and a read of the data address (0x2F) returns 0xFF.
- R2: Writing 0x87, 0x01, 0x55, 0x55 in that order to the index address (0x2E) opens the port on the edge that samples the last byte.
- R3: A key byte that does not match the expected step sends the matcher back to step one. A mismatching 0x87 is counted as a new first key byte, so 0x87 0x01 0x87 0x01 0x55 0x55 opens the port.
- R4: While the port is locked, data-address writes change no register and raise no device strobe, and data-address reads return 0xFF.
- R5: While the port is open, writing a register number to the index address and then reading the data address returns that register. Register 0x20 holds the chip identifier high byte, 0x21 holds the low byte, and any other unassigned global register below 0x30 reads 0x00.
- R6: Register 0x22 reads the 4-bit revision in bits 3:0, with bits 7:4 zero.
- R7: Writing register 0x07 while the port is open sets the logical-device number. The new value appears on dev_ldn the cycle after the write and reads back through register 0x07.
- R8: Register numbers 0x30 and above are forwarded. A data write raises dev_wr and a data read raises dev_rd for that cycle, with dev_addr equal to the register number, dev_wdata equal to the host byte, and dev_ldn equal to the selected device. The host read returns dev_rdata.
- R9: Writing 0x02 to the data address while the index holds 0x02 locks the port. Any other byte written there leaves the port open.
- R10: A strobe to an address other than 0x2E or 0x2F has no effect on any register or on the lock state.
- R11: Reads of the index address return 0xFF, and index writes made while the port is locked do not change the register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 16 | Host I/O address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid while host_rd is high |
| dev_wr | output | 1 | Write strobe to the selected logical device |
| dev_rd | output | 1 | Read strobe to the selected logical device |
| dev_ldn | output | 8 | Selected logical-device number |
| dev_addr | output | 8 | Device register number |
| dev_wdata | output | 8 | Device write byte |
| dev_rdata | input | 8 | Device read byte |

## Verification
The bench aims at the key matcher's recovery paths. One is a stray 0x87 in the middle of the key, which a design that only resets to step zero would reject. Another is a wrong byte just before the final byte, which a design that does not restart would accept. It checks the exit sequence with both the exit code and a different byte. A design that compares only the index or only the data would lock too early or never lock. Writes on a locked port and on foreign addresses are followed by a readback of the device-select register after unlocking, so leaking writes show up as a changed value. A seeded random mix of key bytes, register selects, forwarded accesses and exit writes runs against a bench model of the lock state, the index and the bank select.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
   typedef logic [7:0] byte_t;

   typedef enum logic [1:0] {
      PSEL_NONE  = 2'd0,
      PSEL_INDEX = 2'd1,
      PSEL_DATA  = 2'd2
   } port_sel_e;

   localparam byte_t REG_EXIT   = 8'h02;
   localparam byte_t EXIT_CODE  = 8'h02;
   localparam byte_t REG_BANK   = 8'h07;
   localparam byte_t REG_ID_HI  = 8'h20;
   localparam byte_t REG_ID_LO  = 8'h21;
   localparam byte_t REG_REV    = 8'h22;
   localparam byte_t IDLE_READ  = 8'hFF;
endpackage

// File: rtl/sio_addr_decode.sv
module sio_addr_decode
   import sio_cfg_pkg::*;
#(
   parameter int             AW       = 16,
   parameter int             DEC_BITS = AW,
   parameter logic [AW-1:0]  BASE     = 16'h002E
) (
   input  logic [AW-1:0] addr,
   output port_sel_e     psel
);
   localparam logic [AW-1:0] DATA_ADDR = BASE + 1'b1;

   generate
      if (DEC_BITS >= AW) begin : g_full
         always_comb begin
            if (addr == BASE)           psel = PSEL_INDEX;
            else if (addr == DATA_ADDR) psel = PSEL_DATA;
            else                        psel = PSEL_NONE;
         end
      end else begin : g_partial
         always_comb begin
            if (addr[DEC_BITS-1:0] == BASE[DEC_BITS-1:0])           psel = PSEL_INDEX;
            else if (addr[DEC_BITS-1:0] == DATA_ADDR[DEC_BITS-1:0]) psel = PSEL_DATA;
            else                                                     psel = PSEL_NONE;
         end
      end
   endgenerate
endmodule

// File: rtl/sio_key_match.sv
module sio_key_match
   import sio_cfg_pkg::*;
#(
   parameter int                 KEY_LEN = 4,
   parameter logic [KEY_LEN*8-1:0] KEY_SEQ = 32'h8701_5555
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  key_wr,
   input  byte_t key_byte,
   output logic  key_hit
);
   localparam int SW = (KEY_LEN > 1) ? $clog2(KEY_LEN) : 1;
   localparam logic [SW-1:0] LAST = SW'(KEY_LEN - 1);

   byte_t         step_key [KEY_LEN];
   logic [SW-1:0] step;
   logic          match;
   logic          restart;

   generate
      for (genvar i = 0; i < KEY_LEN; i++) begin : g_key
         assign step_key[i] = KEY_SEQ[(KEY_LEN-1-i)*8 +: 8];
      end
   endgenerate

   always_comb begin
      match   = (key_byte == step_key[step]);
      restart = (key_byte == step_key[0]);
      key_hit = key_wr && match && (step == LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step <= '0;
      end else if (key_wr) begin
         if (match)        step <= (step == LAST) ? '0 : step + 1'b1;
         else if (restart) step <= SW'(1);
         else              step <= '0;
      end
   end
endmodule

// File: rtl/sio_cfg_regs.sv
module sio_cfg_regs
   import sio_cfg_pkg::*;
#(
   parameter logic [15:0] CHIP_ID  = 16'h8A31,
   parameter logic [3:0]  CHIP_REV = 4'h5,
   parameter byte_t       DEV_BASE = 8'h30
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  idx_wr,
   input  logic  dat_wr,
   input  logic  dat_rd,
   input  byte_t wdata,
   input  logic  key_hit,
   input  byte_t dev_rdata,
   output logic  open,
   output byte_t index,
   output byte_t bank,
   output logic  fwd,
   output byte_t rdata
);
   byte_t global_rd;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open  <= 1'b0;
         index <= '0;
         bank  <= '0;
      end else begin
         if (!open && key_hit)
            open <= 1'b1;
         else if (open && dat_wr && index == REG_EXIT && wdata == EXIT_CODE)
            open <= 1'b0;
         if (open && idx_wr)
            index <= wdata;
         if (open && dat_wr && index == REG_BANK)
            bank <= wdata;
      end
   end

   always_comb begin
      fwd = (index >= DEV_BASE);
      unique case (index)
         REG_BANK:  global_rd = bank;
         REG_ID_HI: global_rd = CHIP_ID[15:8];
         REG_ID_LO: global_rd = CHIP_ID[7:0];
         REG_REV:   global_rd = {4'h0, CHIP_REV};
         default:   global_rd = 8'h00;
      endcase
      if (!open || !dat_rd) rdata = IDLE_READ;
      else if (fwd)         rdata = dev_rdata;
      else                  rdata = global_rd;
   end
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
   import sio_cfg_pkg::*;
#(
   parameter int                   AW       = 16,
   parameter int                   DEC_BITS = AW,
   parameter logic [AW-1:0]        BASE     = 16'h002E,
   parameter logic [15:0]          CHIP_ID  = 16'h8A31,
   parameter logic [3:0]           CHIP_REV = 4'h5,
   parameter logic [7:0]           DEV_BASE = 8'h30,
   parameter int                   KEY_LEN  = 4,
   parameter logic [KEY_LEN*8-1:0] KEY_SEQ  = 32'h8701_5555
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic          host_rd,
   input  logic [AW-1:0] host_addr,
   input  logic [7:0]    host_wdata,
   output logic [7:0]    host_rdata,
   output logic          dev_wr,
   output logic          dev_rd,
   output logic [7:0]    dev_ldn,
   output logic [7:0]    dev_addr,
   output logic [7:0]    dev_wdata,
   input  logic [7:0]    dev_rdata
);
   generate
      if (KEY_LEN < 2) begin : g_bad_key
         $error("sio_cfg_port: KEY_LEN must be at least 2");
      end
      if (DEV_BASE <= REG_REV) begin : g_bad_base
         $error("sio_cfg_port: DEV_BASE must sit above the global registers");
      end
      if (BASE[0] != 1'b0) begin : g_bad_addr
         $error("sio_cfg_port: BASE must be even");
      end
      if (DEC_BITS < 2 || DEC_BITS > AW) begin : g_bad_dec
         $error("sio_cfg_port: DEC_BITS out of range");
      end
   endgenerate

   port_sel_e psel;
   logic      idx_wr, dat_wr, dat_rd;
   logic      cfg_open;
   logic      key_hit;
   logic      fwd;
   byte_t     index, bank, reg_rdata;

   sio_addr_decode #(.AW(AW), .DEC_BITS(DEC_BITS), .BASE(BASE)) u_dec (
      .addr (host_addr),
      .psel (psel)
   );

   always_comb begin
      idx_wr = host_wr && (psel == PSEL_INDEX);
      dat_wr = host_wr && (psel == PSEL_DATA);
      dat_rd = host_rd && (psel == PSEL_DATA);
   end

   sio_key_match #(.KEY_LEN(KEY_LEN), .KEY_SEQ(KEY_SEQ)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (idx_wr && !cfg_open),
      .key_byte (host_wdata),
      .key_hit  (key_hit)
   );

   sio_cfg_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV), .DEV_BASE(DEV_BASE)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx_wr    (idx_wr),
      .dat_wr    (dat_wr),
      .dat_rd    (dat_rd),
      .wdata     (host_wdata),
      .key_hit   (key_hit),
      .dev_rdata (dev_rdata),
      .open      (cfg_open),
      .index     (index),
      .bank      (bank),
      .fwd       (fwd),
      .rdata     (reg_rdata)
   );

   always_comb begin
      dev_wr     = cfg_open && fwd && dat_wr;
      dev_rd     = cfg_open && fwd && dat_rd;
      dev_ldn    = bank;
      dev_addr   = index;
      dev_wdata  = host_wdata;
      host_rdata = reg_rdata;
   end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
   parameter int            AW       = 16,
   parameter logic [AW-1:0] BASE     = 16'h002E,
   parameter logic [7:0]    DEV_BASE = 8'h30
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_wr,
   input logic          host_rd,
   input logic [AW-1:0] host_addr,
   input logic [7:0]    host_wdata,
   input logic [7:0]    host_rdata,
   input logic          dev_wr,
   input logic          dev_rd,
   input logic [7:0]    dev_ldn,
   input logic [7:0]    dev_addr,
   input logic          cfg_open
);
   localparam logic [AW-1:0] DATA_ADDR = BASE + 1'b1;

   assert_locked_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |-> !(dev_wr || dev_rd));

   assert_locked_read_ff_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_open && host_rd && host_addr == DATA_ADDR) |-> host_rdata == 8'hFF);

   assert_fwd_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (dev_wr || dev_rd) |-> dev_addr >= DEV_BASE);

   assert_bank_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && host_wr && host_addr == DATA_ADDR && dev_addr == 8'h07)
      |=> dev_ldn == $past(host_wdata));

   assert_exit_locks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && host_wr && host_addr == DATA_ADDR && dev_addr == 8'h02 && host_wdata == 8'h02)
      |=> !cfg_open);

   assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(host_wr && host_addr == BASE && host_wdata == 8'h55));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.AW(AW), .BASE(BASE), .DEV_BASE(DEV_BASE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_wr    (host_wr),
   .host_rd    (host_rd),
   .host_addr  (host_addr),
   .host_wdata (host_wdata),
   .host_rdata (host_rdata),
   .dev_wr     (dev_wr),
   .dev_rd     (dev_rd),
   .dev_ldn    (dev_ldn),
   .dev_addr   (dev_addr),
   .cfg_open   (cfg_open)
);

// File: tb/sim_sio_cfg_port.sv
module sim_sio_cfg_port;
   localparam logic [15:0] IDX = 16'h002E;
   localparam logic [15:0] DAT = 16'h002F;
   localparam logic [15:0] CID = 16'h8A31;
   localparam logic [3:0]  REV = 4'h5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [15:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        dev_wr, dev_rd;
   logic [7:0]  dev_ldn, dev_addr, dev_wdata, dev_rdata;

   int n_chk = 0, n_fail = 0;
   logic done = 1'b0;

   logic       s_dwr, s_drd;
   logic [7:0] s_daddr, s_dwdata, s_dldn, s_rd;

   logic       m_open = 1'b0;
   int         m_step = 0;
   logic [7:0] m_idx = 8'h00, m_ldn = 8'h00;

   always #4 clk = ~clk;

   function automatic logic [7:0] devf(input logic [7:0] ldn, input logic [7:0] a);
      return a ^ {ldn[3:0], ldn[7:4]} ^ 8'hA5;
   endfunction

   assign dev_rdata = devf(dev_ldn, dev_addr);

   sio_cfg_port u0 (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .dev_wr(dev_wr), .dev_rd(dev_rd), .dev_ldn(dev_ldn), .dev_addr(dev_addr),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
   );

   function automatic logic [7:0] key_at(input int s);
      case (s)
         0: return 8'h87;
         1: return 8'h01;
         default: return 8'h55;
      endcase
   endfunction

   function automatic logic [7:0] exp_rd(input logic [15:0] a);
      if (a != DAT || !m_open) return 8'hFF;
      if (m_idx >= 8'h30) return devf(m_ldn, m_idx);
      case (m_idx)
         8'h07: return m_ldn;
         8'h20: return CID[15:8];
         8'h21: return CID[7:0];
         8'h22: return {4'h0, REV};
         default: return 8'h00;
      endcase
   endfunction

   task automatic model_wr(input logic [15:0] a, input logic [7:0] d);
      if (a == IDX) begin
         if (m_open) m_idx = d;
         else if (d == key_at(m_step)) begin
            if (m_step == 3) begin m_open = 1'b1; m_step = 0; end
            else m_step++;
         end else if (d == 8'h87) m_step = 1;
         else m_step = 0;
      end else if (a == DAT && m_open) begin
         if (m_idx == 8'h07) m_ldn = d;
         if (m_idx == 8'h02 && d == 8'h02) m_open = 1'b0;
      end
   endtask

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      #1;
      s_dwr = dev_wr; s_daddr = dev_addr; s_dwdata = dev_wdata; s_dldn = dev_ldn;
      @(negedge clk);
      host_wr = 1'b0;
      model_wr(a, d);
   endtask

   task automatic io_rd(input logic [15:0] a);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      #1;
      s_rd = host_rdata; s_drd = dev_rd; s_daddr = dev_addr; s_dldn = dev_ldn;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a);
      logic [7:0] e;
      e = exp_rd(a);
      io_rd(a);
      chk(req, s_rd, e);
   endtask

   task automatic unlock();
      io_wr(IDX, 8'h87); io_wr(IDX, 8'h01); io_wr(IDX, 8'h55); io_wr(IDX, 8'h55);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk("R1 ldn", dev_ldn, 8'h00);
      rd_chk("R1 locked read", DAT);
      // R4 locked data write
      io_wr(DAT, 8'h44);
      chk("R4 no dev_wr", {7'd0, s_dwr}, 8'h00);
      io_rd(DAT);
      chk("R4 read ff", s_rd, 8'hFF);
      chk("R4 no dev_rd", {7'd0, s_drd}, 8'h00);
      // R3 broken key then restart via 0x87
      io_wr(IDX, 8'h87); io_wr(IDX, 8'h01); io_wr(IDX, 8'h55); io_wr(IDX, 8'h00);
      io_wr(IDX, 8'h55);
      rd_chk("R3 still locked", DAT);
      io_wr(IDX, 8'h87); io_wr(IDX, 8'h01); io_wr(IDX, 8'h87); io_wr(IDX, 8'h01);
      io_wr(IDX, 8'h55); io_wr(IDX, 8'h55);
      chk("R3 model open", {7'd0, m_open}, 8'h01);
      // R11 index unchanged by locked writes; R2 open
      rd_chk("R11 idx zero after unlock", DAT);
      io_rd(IDX);
      chk("R11 index read ff", s_rd, 8'hFF);
      io_wr(IDX, 8'h07);
      rd_chk("R4 ldn untouched", DAT);
      // R5 / R6
      io_wr(IDX, 8'h20); rd_chk("R5 id hi", DAT);
      io_wr(IDX, 8'h21); rd_chk("R5 id lo", DAT);
      io_wr(IDX, 8'h10); rd_chk("R5 unassigned", DAT);
      io_wr(IDX, 8'h22); rd_chk("R6 revision", DAT);
      // R7
      io_wr(IDX, 8'h07); io_wr(DAT, 8'h3C);
      chk("R7 dev_ldn", dev_ldn, 8'h3C);
      rd_chk("R7 readback", DAT);
      // R8
      io_wr(IDX, 8'h45); io_wr(DAT, 8'h9A);
      chk("R8 dev_wr", {7'd0, s_dwr}, 8'h01);
      chk("R8 dev_addr", s_daddr, 8'h45);
      chk("R8 dev_wdata", s_dwdata, 8'h9A);
      chk("R8 dev_ldn", s_dldn, 8'h3C);
      io_rd(DAT);
      chk("R8 dev_rd", {7'd0, s_drd}, 8'h01);
      chk("R8 read", s_rd, devf(8'h3C, 8'h45));
      io_wr(IDX, 8'h2F);
      io_wr(DAT, 8'h11);
      chk("R8 no fwd below base", {7'd0, s_dwr}, 8'h00);
      // R10 foreign addresses
      io_wr(IDX, 8'h07);
      io_wr(16'h012F, 8'h11);
      io_wr(16'h012E, 8'h20);
      io_wr(16'h0030, 8'h02);
      rd_chk("R10 ldn kept", DAT);
      // R9
      io_wr(IDX, 8'h02); io_wr(DAT, 8'h05);
      chk("R9 stays open", {7'd0, m_open}, 8'h01);
      io_wr(IDX, 8'h07); rd_chk("R9 open read", DAT);
      io_wr(IDX, 8'h02); io_wr(DAT, 8'h02);
      rd_chk("R9 locked", DAT);
      // random phase against bench model
      void'($urandom(32'd1234));
      for (int i = 0; i < 400; i++) begin
         int         k;
         logic [7:0] d;
         logic       e_dw;
         k = $urandom_range(0, 9);
         case (k)
            0, 1, 2: begin
               case ($urandom_range(0, 3))
                  0: d = 8'h87; 1: d = 8'h01; 2: d = 8'h55; default: d = 8'($urandom);
               endcase
               io_wr(IDX, d);
            end
            3, 4: begin
               case ($urandom_range(0, 5))
                  0: d = 8'h02; 1: d = 8'h07; 2: d = 8'h20; 3: d = 8'h22;
                  4: d = 8'h30 + 8'($urandom_range(0, 63)); default: d = 8'($urandom);
               endcase
               io_wr(IDX, d);
            end
            5, 6: begin
               d = ($urandom_range(0, 3) == 0) ? 8'h02 : 8'($urandom);
               e_dw = m_open && (m_idx >= 8'h30);
               io_wr(DAT, d);
               chk("R8 random dev_wr", {7'd0, s_dwr}, {7'd0, e_dw});
            end
            7, 8: rd_chk("R5 random read", DAT);
            default: io_wr(16'h0100 + 16'($urandom_range(0, 255)), 8'($urandom));
         endcase
      end
      chk("R7 random ldn", dev_ldn, m_ldn);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule